// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small single-ported word memory and shares it among several requesters. Each requester presents an opcode, a word address, a write operand and a compare operand, and holds its request until it is answered. A round-robin arbiter admits one request at a time. The admitted request is then carried through a read cycle and a write cycle that belong to it alone, so test-and-set, swap and compare-and-swap are indivisible with respect to every other requester.

The controller has two states. `S_ARB_READ` picks a winner among the asserted requests, latches its fields and reads the addressed word. The transition `ARB_TO_WRITE` is taken when any request is present; otherwise the state stays `S_ARB_READ` (transition `ARB_IDLE_HOLD`). `S_WRITE_RESP` decides whether to write and what to write from the word just read, performs the write, and raises a one-cycle response to the granted requester. It always returns to `S_ARB_READ` (transition `WRITE_TO_ARB`). A granted operation thus takes exactly two cycles, and a new grant can be made in the cycle right after a response.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset no response is raised, no grant is active, and every memory word reads as zero.
- R2: Opcode 0 (load) returns the stored word, leaves memory unchanged and reports status 0 (success).
- R3: Opcode 1 (store) writes the write operand to the address, returns data 0 and reports status 0.
- R4: Opcode 2 (test-and-set) returns the old word and writes the value 1, status 0.
- R5: Opcode 3 (swap) returns the old word and writes the write operand, status 0.
- R6: Opcode 4 (compare-and-swap) with compare operand equal to the stored word writes the write operand, returns the old word (equal to the compare operand) and reports status 0.
- R7: Compare-and-swap with a mismatching compare operand leaves memory unchanged, returns the old word and reports status 1 (fail).
- R8: Opcodes 5, 6 and 7 return data 0 with status 2 (error) and leave memory unchanged.
- R9: A request that is granted on a clock edge is answered in the cycle that follows it; the response is one cycle long and goes to exactly one requester, which is the one that was granted, and no grant is made in the response cycle.
- R10: Among asserted requests, the grant goes to the first one found scanning upward (with wrap) from the index after the most recently granted requester; after reset the scan starts at requester 0.
- R11: No other access reaches memory between the read and the write of a granted operation, so concurrent test-and-sets of one word give the old value 0 to exactly one requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Request pending, one bit per requester, held until its response |
| req_op | input | NUM_REQ x 3 | Opcode per requester |
| req_addr | input | NUM_REQ x ADDR_W | Word address per requester |
| req_wdata | input | NUM_REQ x DATA_W | Store, swap or compare-and-swap new value |
| req_cmp | input | NUM_REQ x DATA_W | Compare-and-swap expected value |
| rsp_valid | output | NUM_REQ | One-cycle response strobe, one bit per requester |
| rsp_data | output | DATA_W | Returned word (old value, or 0 for store and error) |
| rsp_status | output | 2 | 0 success, 1 compare fail, 2 bad opcode |

## Verification
The bench drives three requesters at once against a test-and-set lock word and checks that exactly one of them sees zero; a design that let another access slip between the read and the write would hand the lock to two. Compare-and-swap is driven both with a matching and a stale expected value, catching a unit that writes on mismatch or reports the wrong status. Illegal opcodes are followed by a load of the same word to show that memory was not touched, and every clock the bench predicts whether a response is due and which requester round-robin order must pick, so an extra cycle of latency, a stuck or doubled response, or a pointer that fails to rotate is seen at once.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam logic [2:0] OP_LOAD  = 3'd0;
    localparam logic [2:0] OP_STORE = 3'd1;
    localparam logic [2:0] OP_TAS   = 3'd2;
    localparam logic [2:0] OP_SWAP  = 3'd3;
    localparam logic [2:0] OP_CAS   = 3'd4;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_FAIL = 2'd1,
        ST_ERR  = 2'd2
    } amu_status_e;

    typedef enum logic {
        S_ARB_READ   = 1'b0,
        S_WRITE_RESP = 1'b1
    } amu_state_e;

endpackage

// File: rtl/amu_rr_arb.sv
module amu_rr_arb #(
    parameter int NUM_REQ = 3,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    input  logic               take,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic               gnt_any
);

    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            int cand;
            cand = (int'(ptr_q) + k) % NUM_REQ;
            if (!gnt_any && req[cand]) begin
                gnt_any = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take && gnt_any) begin
            if (int'(gnt_idx) == NUM_REQ - 1)
                ptr_q <= '0;
            else
                ptr_q <= gnt_idx + 1'b1;
        end
    end

    AST_GRANT_IS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> req[gnt_idx]);  // R10

endmodule

// File: rtl/amu_word_mem.sv
module amu_word_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) cells[wr_addr] <= wr_data;
            if (rd_en) rd_data <= cells[rd_addr];
        end
    end

    AST_ONE_PORT_USE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));  // R11

endmodule

// File: rtl/amu_exec.sv
module amu_exec
    import amu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] expected,
    output logic              do_write,
    output logic [DATA_W-1:0] new_word,
    output logic [DATA_W-1:0] ret_word,
    output amu_status_e       status
);

    always_comb begin
        do_write = 1'b0;
        new_word = operand;
        ret_word = old_word;
        status   = ST_OK;
        unique case (op)
            OP_LOAD: begin
            end
            OP_STORE: begin
                do_write = 1'b1;
                ret_word = '0;
            end
            OP_TAS: begin
                do_write = 1'b1;
                new_word = DATA_W'(1);
            end
            OP_SWAP: begin
                do_write = 1'b1;
            end
            OP_CAS: begin
                if (old_word == expected) begin
                    do_write = 1'b1;
                end else begin
                    status = ST_FAIL;
                end
            end
            default: begin
                ret_word = '0;
                status   = ST_ERR;
            end
        endcase
    end

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
    import amu_pkg::*;
#(
    parameter int NUM_REQ = 3,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REQ-1:0]              req_valid,
    input  logic [NUM_REQ-1:0][2:0]         req_op,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]  req_addr,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]  req_wdata,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]  req_cmp,
    output logic [NUM_REQ-1:0]              rsp_valid,
    output logic [DATA_W-1:0]               rsp_data,
    output logic [1:0]                      rsp_status
);

    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    amu_state_e        state_q, state_d;
    logic [IDX_W-1:0]  gnt_idx, gnt_q;
    logic              gnt_any, take;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, cmp_q;
    logic [DATA_W-1:0] old_word, new_word, ret_word;
    logic              do_write, mem_we;
    amu_status_e       ex_status;

    amu_rr_arb #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .take    (take),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    amu_word_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (take),
        .rd_addr (req_addr[gnt_idx]),
        .rd_data (old_word),
        .wr_en   (mem_we),
        .wr_addr (addr_q),
        .wr_data (new_word)
    );

    amu_exec #(.DATA_W(DATA_W)) u_exec (
        .op       (op_q),
        .old_word (old_word),
        .operand  (wdata_q),
        .expected (cmp_q),
        .do_write (do_write),
        .new_word (new_word),
        .ret_word (ret_word),
        .status   (ex_status)
    );

    // State register and latched request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_ARB_READ;
            gnt_q   <= '0;
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            cmp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                gnt_q   <= gnt_idx;
                op_q    <= req_op[gnt_idx];
                addr_q  <= req_addr[gnt_idx];
                wdata_q <= req_wdata[gnt_idx];
                cmp_q   <= req_cmp[gnt_idx];
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        take       = 1'b0;
        mem_we     = 1'b0;
        rsp_valid  = '0;
        rsp_data   = '0;
        rsp_status = ST_OK;
        unique case (state_q)
            S_ARB_READ: begin
                if (gnt_any) begin
                    take    = 1'b1;
                    state_d = S_WRITE_RESP;
                end
            end
            S_WRITE_RESP: begin
                mem_we            = do_write;
                rsp_valid[gnt_q]  = 1'b1;
                rsp_data          = ret_word;
                rsp_status        = ex_status;
                state_d           = S_ARB_READ;
            end
            default: state_d = S_ARB_READ;
        endcase
    end

    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));  // R9
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |=> !(|rsp_valid));  // R9
    AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |-> $past(take));  // R9
    AST_WRITE_ONLY_IN_OWN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (|rsp_valid) && $past(take));  // R11
    AST_CAS_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_valid) && rsp_status == ST_FAIL) |-> !mem_we);  // R7
    AST_BAD_OP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_valid) && rsp_status == ST_ERR) |-> (!mem_we && rsp_data == '0));  // R8
    AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_valid) && op_q == OP_STORE) |-> (rsp_data == '0 && rsp_status == ST_OK));  // R3

endmodule

// File: tb/tb_atomic_mem_unit.sv
`timescale 1ns/1ps
module tb_atomic_mem_unit;

    localparam int N  = 3;
    localparam int DW = 32;
    localparam int AW = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [N-1:0]            req_valid = '0;
    logic [N-1:0][2:0]       req_op = '0;
    logic [N-1:0][AW-1:0]    req_addr = '0;
    logic [N-1:0][DW-1:0]    req_wdata = '0;
    logic [N-1:0][DW-1:0]    req_cmp = '0;
    logic [N-1:0]            rsp_valid;
    logic [DW-1:0]           rsp_data;
    logic [1:0]              rsp_status;

    atomic_mem_unit #(.NUM_REQ(N), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status)
    );

    always #5 clk = ~clk;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [DW-1:0] model [1 << AW];
    int          last_served = N - 1;
    bit          rsp_prev = 1'b0;
    bit [N-1:0]  done = '0;
    logic [DW-1:0] last_ret [N];
    int          zero_wins = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rr_pick(input logic [N-1:0] req, input int last);
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (last + k) % N;
            if (req[c]) return c;
        end
        return -1;
    endfunction

    // Reference model, compared every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_rsp;
            exp_rsp = !rsp_prev && (|req_valid);
            check((|rsp_valid) == exp_rsp, "R9 response timing", longint'(rsp_valid), longint'(exp_rsp));
            if (|rsp_valid) begin
                int r, w;
                logic [2:0] op;
                logic [AW-1:0] a;
                logic [DW-1:0] old, ed;
                logic [1:0] es;
                check($onehot(rsp_valid), "R9 single requester", longint'(rsp_valid), 1);
                r = 0;
                for (int i = 0; i < N; i++) if (rsp_valid[i]) r = i;
                w = rr_pick(req_valid, last_served);
                check(r == w, "R10 round-robin winner", r, w);
                op  = req_op[r];
                a   = req_addr[r];
                old = model[a];
                ed  = old;
                es  = 2'd0;
                case (op)
                    3'd0: ;
                    3'd1: begin model[a] = req_wdata[r]; ed = '0; end
                    3'd2: model[a] = 1;
                    3'd3: model[a] = req_wdata[r];
                    3'd4: if (old == req_cmp[r]) model[a] = req_wdata[r]; else es = 2'd1;
                    default: begin ed = '0; es = 2'd2; end
                endcase
                check(rsp_data == ed, $sformatf("R2-R8 data op%0d (R%0d)", op, (op > 4) ? 8 : op + 2),
                      longint'(rsp_data), longint'(ed));
                check(rsp_status == es, $sformatf("status op%0d (R%0d)", op, (op > 4) ? 8 : op + 2),
                      longint'(rsp_status), longint'(es));
                last_ret[r] = rsp_data;
                last_served = r;
                req_valid[r] = 1'b0;
                done[r] = 1'b1;
            end
            rsp_prev = |rsp_valid;
        end
    end

    task automatic post(input int r, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [DW-1:0] cp);
        done[r]      = 1'b0;
        req_op[r]    = op;
        req_addr[r]  = a;
        req_wdata[r] = wd;
        req_cmp[r]   = cp;
        req_valid[r] = 1'b1;
    endtask

    task automatic issue(input int r, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic [DW-1:0] cp);
        @(negedge clk); #1;
        post(r, op, a, wd, cp);
        wait (done[r]);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == '0, "R1 no response after reset", longint'(rsp_valid), 0);
        issue(0, 3'd0, 4'd5, 0, 0);
        check(last_ret[0] == 0, "R1 memory zero after reset", longint'(last_ret[0]), 0);

        issue(1, 3'd1, 4'd3, 32'h1234, 0);                // R3 store
        issue(1, 3'd0, 4'd3, 0, 0);                       // R2 load
        check(last_ret[1] == 32'h1234, "R2 load after store", longint'(last_ret[1]), 32'h1234);

        issue(2, 3'd2, 4'd7, 0, 0);                       // R4 test-and-set, free
        check(last_ret[2] == 0, "R4 first tas old", longint'(last_ret[2]), 0);
        issue(2, 3'd2, 4'd7, 0, 0);                       // R4 held
        check(last_ret[2] == 1, "R4 second tas old", longint'(last_ret[2]), 1);

        issue(0, 3'd3, 4'd3, 32'hAAAA, 0);                // R5 swap
        check(last_ret[0] == 32'h1234, "R5 swap old", longint'(last_ret[0]), 32'h1234);

        issue(1, 3'd4, 4'd3, 32'h55, 32'hAAAA);           // R6 cas success
        check(last_ret[1] == 32'hAAAA, "R6 cas returns expected", longint'(last_ret[1]), 32'hAAAA);
        issue(1, 3'd4, 4'd3, 32'h66, 32'hAAAA);           // R7 cas fail
        issue(1, 3'd0, 4'd3, 0, 0);
        check(last_ret[1] == 32'h55, "R7 cas fail left memory", longint'(last_ret[1]), 32'h55);

        for (int op = 5; op < 8; op++) begin               // R8 illegal opcodes
            issue(2, 3'(op), 4'd3, 32'hDEAD, 32'h55);
            issue(2, 3'd0, 4'd3, 0, 0);
            check(last_ret[2] == 32'h55, "R8 bad opcode left memory", longint'(last_ret[2]), 32'h55);
        end

        // R11 contention on one lock word, R10 rotation
        for (int round = 0; round < 4; round++) begin
            logic [AW-1:0] lk;
            lk = AW'(9 + round);
            @(negedge clk); #1;
            for (int r = 0; r < N; r++) post(r, 3'd2, lk, 0, 0);
            wait (&done);
            zero_wins = 0;
            for (int r = 0; r < N; r++) if (last_ret[r] == 0) zero_wins++;
            check(zero_wins == 1, "R11 single lock winner", zero_wins, 1);
        end

        // Mixed concurrent traffic, R10 with partial request sets
        @(negedge clk); #1;
        post(0, 3'd3, 4'd2, 32'h11, 0);
        post(2, 3'd4, 4'd2, 32'h22, 32'h11);
        wait (done[0] && done[2]);
        @(negedge clk); #1;
        post(1, 3'd1, 4'd4, 32'h77, 0);
        post(2, 3'd0, 4'd2, 0, 0);
        wait (done[1] && done[2]);
        issue(0, 3'd0, 4'd4, 0, 0);
        check(last_ret[0] == 32'h77, "R3 concurrent store visible", longint'(last_ret[0]), 32'h77);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule